// File: doc/BRIEF.md
# Dual USB device address filter

This block lets a single USB function answer on the bus as two logical devices, which is how a compound device is built. It holds two device address registers, A and B. Each register has an 8-bit layout: bits 6 to 0 hold the 7-bit device address and bit 7 is the enable. Firmware loads the address the host assigned during enumeration and then sets the enable bit.

For every token address presented with a valid strobe, the block compares the address against both registers. One cycle later it reports whether the token is for this function, which logical device it belongs to, and how many endpoints that device owns under the current endpoint mode. A mode input selects between single-device operation, where only register A can match, and compound operation, where both registers can match. Token parsing and the endpoint FIFOs sit outside this block.

Top module: `dual_addr_filter`

## Requirements
- R1: After reset both registers read back 0x00, and match_o, dev_sel_o and ep_count_o are 0.
- R2: A write with reg_we_i high loads reg_wdata_i into register A when sel_a_i is high and into register B when sel_b_i is high. reg_rdata_o shows register A while sel_a_i is high, register B while only sel_b_i is high, and 0x00 while neither is high. The value shown is exactly the 8 bits last written.
- R3: A register whose bit 7 (the enable) is 0 never produces a match, even when its bits 6 to 0 equal the token address.
- R4: If tok_valid_i is high and tok_addr_i equals bits 6 to 0 of an enabled register A, then in the next cycle match_o is 1 and dev_sel_o is 0.
- R5: In compound mode (dual_mode_i = 1), a valid token whose address equals bits 6 to 0 of an enabled register B, and which does not match A, gives match_o = 1 and dev_sel_o = 1 in the next cycle.
- R6: If both registers are enabled and hold the same address, a token at that address selects device A (dev_sel_o = 0).
- R7: In single-device mode (dual_mode_i = 0), register B never produces a match, even when it is enabled.
- R8: While match_o is 1, ep_count_o gives the endpoints of the selected device: 3 for A and 2 for B in compound mode, and 5 for A in single-device mode.
- R9: A cycle with no valid token, or with a valid token that matches neither device, gives match_o = 0, dev_sel_o = 0 and ep_count_o = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_a_i | input | 1 | Selects address register A |
| sel_b_i | input | 1 | Selects address register B |
| reg_we_i | input | 1 | Write strobe for the selected register(s) |
| reg_wdata_i | input | 8 | Write data: bit 7 is the enable, bits 6 to 0 are the address |
| reg_rdata_o | output | 8 | Read data of the selected register |
| dual_mode_i | input | 1 | 1 = compound operation (two addresses), 0 = single device |
| tok_valid_i | input | 1 | Token address valid strobe |
| tok_addr_i | input | 7 | Address field of the received token |
| match_o | output | 1 | Token was for this function (registered) |
| dev_sel_o | output | 1 | Matched device: 0 = A, 1 = B |
| ep_count_o | output | 3 | Endpoint count of the matched device |

## Verification
On every cycle, the assertions check that a match always comes from a valid token and an enabled register. They also check that a device-B match never occurs in single-device mode or when A would have claimed the same address, and that a reported match carries a nonzero endpoint count. Only the directed scenarios can show the exact register readback and the endpoint counts for each mode. They also cover misses at addresses close to a programmed one, the effect of clearing an enable bit, and a write that loads both registers at once.

// File: rtl/dual_addr_pkg.sv
package dual_addr_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned REG_W  = ADDR_W + 1;
  localparam int unsigned N_DEV  = 2;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
  } dev_reg_t;
endpackage

// File: rtl/dual_addr_reg.sv
module dual_addr_reg
  import dual_addr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  dev_reg_t wdata_i,
  output dev_reg_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/dual_addr_cmp.sv
module dual_addr_cmp
  import dual_addr_pkg::*;
(
  input  dev_reg_t          reg_a_i,
  input  dev_reg_t          reg_b_i,
  input  logic              dual_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              hit_b_o
);
  logic eq_a, eq_b;

  always_comb begin
    eq_a    = reg_a_i.en && (reg_a_i.addr == addr_i);
    eq_b    = dual_mode_i && reg_b_i.en && (reg_b_i.addr == addr_i);
    hit_o   = eq_a || eq_b;
    hit_b_o = eq_b && !eq_a;  // A wins on shared address
  end
endmodule

// File: rtl/dual_addr_filter.sv
module dual_addr_filter
  import dual_addr_pkg::*;
#(
  parameter int unsigned EP_SINGLE = 5,
  parameter int unsigned EP_A_DUAL = 3,
  parameter int unsigned EP_B_DUAL = 2,
  localparam int unsigned EP_W = $clog2(EP_SINGLE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              dual_mode_i,
  input  logic              tok_valid_i,
  input  logic [ADDR_W-1:0] tok_addr_i,
  output logic              match_o,
  output logic              dev_sel_o,
  output logic [EP_W-1:0]   ep_count_o
);
  dev_reg_t [N_DEV-1:0] regs_q;
  logic     [N_DEV-1:0] sel;
  logic hit, hit_b;
  logic [EP_W-1:0] ep_next;

  assign sel = {sel_b_i, sel_a_i};

  for (genvar d = 0; d < N_DEV; d++) begin : g_reg
    dual_addr_reg u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (reg_we_i && sel[d]),
      .wdata_i (dev_reg_t'(reg_wdata_i)),
      .q_o     (regs_q[d])
    );
  end

  always_comb begin
    if (sel_a_i)      reg_rdata_o = regs_q[0];
    else if (sel_b_i) reg_rdata_o = regs_q[1];
    else              reg_rdata_o = '0;
  end

  dual_addr_cmp u_cmp (
    .reg_a_i     (regs_q[0]),
    .reg_b_i     (regs_q[1]),
    .dual_mode_i (dual_mode_i),
    .addr_i      (tok_addr_i),
    .hit_o       (hit),
    .hit_b_o     (hit_b)
  );

  always_comb begin
    if (!dual_mode_i) ep_next = EP_W'(EP_SINGLE);
    else if (hit_b)   ep_next = EP_W'(EP_B_DUAL);
    else              ep_next = EP_W'(EP_A_DUAL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o    <= 1'b0;
      dev_sel_o  <= 1'b0;
      ep_count_o <= '0;
    end else if (tok_valid_i && hit) begin
      match_o    <= 1'b1;
      dev_sel_o  <= hit_b;
      ep_count_o <= ep_next;
    end else begin
      match_o    <= 1'b0;
      dev_sel_o  <= 1'b0;
      ep_count_o <= '0;
    end
  end

  // R9: a match needs a valid token one cycle earlier
  assert_match_needs_token_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(tok_valid_i));

  // R3: the matched device was enabled
  assert_match_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (dev_sel_o ? $past(regs_q[1].en) : $past(regs_q[0].en)));

  // R7: no device B match in single-device mode
  assert_no_b_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && dev_sel_o) |-> $past(dual_mode_i));

  // R6: B never wins when A would have matched
  assert_a_priority_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && dev_sel_o) |-> !($past(regs_q[0].en) && $past(regs_q[0].addr) == $past(tok_addr_i)));

  // R8: a match carries a nonzero endpoint count, no match carries zero
  assert_ep_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o == (ep_count_o != '0));
endmodule

// File: tb/dual_addr_filter_bench.sv
module dual_addr_filter_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_a = 1'b0, sel_b = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       dual = 1'b1;
  logic       tvalid = 1'b0;
  logic [6:0] taddr = '0;
  logic       match, dsel;
  logic [2:0] epc;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_addr_filter u_dual_addr_filter (
    .clk_i(clk), .rst_ni(rst_n), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .dual_mode_i(dual), .tok_valid_i(tvalid), .tok_addr_i(taddr),
    .match_o(match), .dev_sel_o(dsel), .ep_count_o(epc)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(bit a, bit b, logic [7:0] v);
    @(negedge clk);
    sel_a = a; sel_b = b; we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0; sel_a = 1'b0; sel_b = 1'b0;
  endtask

  task automatic read_chk(string req, bit a, bit b, logic [7:0] exp);
    @(negedge clk);
    sel_a = a; sel_b = b;
    #1 check(req, rdata, exp);
    sel_a = 1'b0; sel_b = 1'b0;
  endtask

  // send one token, check outputs the following cycle
  task automatic token_chk(string req, logic [6:0] ad, bit m, bit d, int ep);
    @(negedge clk);
    tvalid = 1'b1; taddr = ad;
    @(negedge clk);
    tvalid = 1'b0;
    check({req, " match"}, match, m);
    check({req, " dev_sel"}, dsel, d);
    check({req, " ep_count"}, epc, ep);
  endtask

  task automatic t_reset;
    check("R1 match", match, 0);
    check("R1 dev_sel", dsel, 0);
    check("R1 ep_count", epc, 0);
    read_chk("R1 reg A", 1, 0, 8'h00);
    read_chk("R1 reg B", 0, 1, 8'h00);
    token_chk("R1 addr0 disabled", 7'd0, 0, 0, 0);
  endtask

  task automatic t_readback;
    write_reg(1, 0, 8'h15);
    write_reg(0, 1, 8'hAA);
    read_chk("R2 reg A", 1, 0, 8'h15);
    read_chk("R2 reg B", 0, 1, 8'hAA);
    read_chk("R2 none", 0, 0, 8'h00);
    write_reg(1, 1, 8'h3C);
    read_chk("R2 both A", 1, 0, 8'h3C);
    read_chk("R2 both B", 0, 1, 8'h3C);
  endtask

  task automatic t_disabled;
    dual = 1'b1;
    write_reg(1, 0, 8'h15);
    write_reg(0, 1, 8'h22);
    token_chk("R3 A disabled", 7'h15, 0, 0, 0);
    token_chk("R3 B disabled", 7'h22, 0, 0, 0);
  endtask

  task automatic t_compound;
    dual = 1'b1;
    write_reg(1, 0, 8'h80 | 8'h15);
    write_reg(0, 1, 8'h80 | 8'h22);
    token_chk("R4 A match", 7'h15, 1, 0, 3);
    token_chk("R5 B match", 7'h22, 1, 1, 2);
    token_chk("R8 A count", 7'h15, 1, 0, 3);
    token_chk("R9 miss near A", 7'h14, 0, 0, 0);
    token_chk("R9 miss near B", 7'h23, 0, 0, 0);
    @(negedge clk);
    taddr = 7'h15; tvalid = 1'b0;
    @(negedge clk);
    check("R9 no valid", match, 0);
    write_reg(1, 0, 8'h15);
    token_chk("R3 A cleared enable", 7'h15, 0, 0, 0);
    token_chk("R5 B still", 7'h22, 1, 1, 2);
  endtask

  task automatic t_priority;
    dual = 1'b1;
    write_reg(1, 1, 8'h80 | 8'h41);
    token_chk("R6 shared addr", 7'h41, 1, 0, 3);
    write_reg(1, 0, 8'h41);
    token_chk("R6 A off B takes", 7'h41, 1, 1, 2);
  endtask

  task automatic t_single;
    write_reg(1, 0, 8'h80 | 8'h7F);
    write_reg(0, 1, 8'h80 | 8'h05);
    dual = 1'b0;
    token_chk("R7 B ignored", 7'h05, 0, 0, 0);
    token_chk("R8 single A", 7'h7F, 1, 0, 5);
    dual = 1'b1;
    token_chk("R7 B back in compound", 7'h05, 1, 1, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_readback;
    t_disabled;
    t_compound;
    t_priority;
    t_single;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule